// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator

This block drives eight pulse-width modulated outputs. Each channel owns an up or up/down counter, a period value and a duty value, and it produces a waveform whose active level, alignment and time base are set through a simple register write port. Two shared base rates (A and B) are derived from the system clock by power-of-two division, and two further rates (SA and SB) are derived from those by an extra programmable count. Any channel can run from any of the four.

Neighbouring channels can be joined in pairs to form a 16-bit channel for long periods or fine duty resolution. Period and duty values are shadowed: software may rewrite them at any time, and a running channel adopts them only at the end of its current period, so no runt or stretched pulse appears. An emergency shutdown input pulls every output low at once, whatever the channels are doing.

Top module: `pwm_mc`

## Requirements
- R1: After reset all configuration registers read as zero except polarity, which is all ones; every output is low and every channel disabled.
- R2: A left-aligned enabled channel with period P counts 0 up to P-1 on its selected tick and repeats, so one period lasts P ticks; the channel is active while its count is below the duty value D.
- R3: A center-aligned channel (its center bit set) counts 0 up to P-1, holds P-1 for one more tick, counts down to 0 and holds 0 once more, so one period lasts 2P ticks and the active time is 2*min(D,P) ticks centred on the period boundary.
- R4: A duty value equal to or above the period gives an output that is active for the whole period; a duty of 0 gives an output that is never active.
- R5: Polarity bit 1 drives the pin high while active and low otherwise; polarity bit 0 inverts this. A disabled channel rests at the inactive level, i.e. the inverse of its polarity bit.
- R6: Each channel's 2-bit source code selects its tick: 0 = A, 1 = B, 2 = SA, 3 = SB. A ticks once every 2^ea clocks and B once every 2^eb clocks; SA ticks on every (sa+1)-th A tick and SB on every (sb+1)-th B tick.
- R7: Period and duty written to an enabled channel take effect only when its current period ends; while the channel is disabled a written value is taken at once, so the first period after enabling uses it.
- R8: With join bit k set, channels 2k and 2k+1 form one 16-bit channel whose period is {period[2k+1], period[2k]} and duty {duty[2k+1], duty[2k]}; enable, polarity, alignment and source come from channel 2k+1, the waveform appears on pin 2k+1, and pin 2k is held low.
- R9: While the shutdown input is high every output is low; the counters keep running.
- R10: A write (wr_en high at a rising clock edge) stores wr_data at wr_addr: 0 enable bits, 1 polarity bits, 2 center bits, 3 source codes of channels 0-3 (channel n at bits 2n+1:2n), 4 source codes of channels 4-7, 5 join bits [3:0], 6 ea at [2:0] and eb at [6:4], 7 sa, 8 sb, 16+n period of channel n, 24+n duty of channel n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 8 | Register write data |
| sd_i | input | 1 | Emergency shutdown, forces all outputs low |
| pwm_o | output | 8 | Channel outputs |

## Verification
The bench measures active time over a window that is a whole number of periods, so a counter that ran one step long, missed the turnaround hold in center mode, or wrapped at P instead of P-1 shows up as a wrong high-cycle count. Duty at and beyond the period and duty of zero are probed, because an off-by-one compare would leave a one-tick glitch or gap. A duty rewrite in the middle of a running period is checked both before and after the period boundary, catching a design that updates immediately or never. The joined pair is run with a period above 255, which fails if the high byte is ignored or the low pin is left driving.

// File: rtl/pwm_mc_pkg.sv
package pwm_mc_pkg;

    typedef enum logic [1:0] {
        SRC_A  = 2'd0,
        SRC_B  = 2'd1,
        SRC_SA = 2'd2,
        SRC_SB = 2'd3
    } pwm_src_e;

    localparam logic [3:0] ADDR_ENABLE = 4'd0;
    localparam logic [3:0] ADDR_POL    = 4'd1;
    localparam logic [3:0] ADDR_CENTER = 4'd2;
    localparam logic [3:0] ADDR_SRC_LO = 4'd3;
    localparam logic [3:0] ADDR_SRC_HI = 4'd4;
    localparam logic [3:0] ADDR_JOIN   = 4'd5;
    localparam logic [3:0] ADDR_EXP    = 4'd6;
    localparam logic [3:0] ADDR_SCL_A  = 4'd7;
    localparam logic [3:0] ADDR_SCL_B  = 4'd8;

endpackage

// File: rtl/pwm_mc_prescale.sv
module pwm_mc_prescale #(
    parameter int DW = 8,
    parameter int EW = 3,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [EW-1:0] exp_a,
    input  logic [EW-1:0] exp_b,
    input  logic [SW-1:0] scale_a,
    input  logic [SW-1:0] scale_b,
    output logic [3:0]    tick_o
);
    typedef struct packed {
        logic [DW-1:0] div;
        logic [SW-1:0] sa;
        logic [SW-1:0] sb;
    } ps_t;

    ps_t s_q, s_d;
    logic [DW-1:0] mask_a, mask_b;
    logic tick_a, tick_b, tick_sa, tick_sb;

    always_comb begin
        mask_a  = ~({DW{1'b1}} << exp_a);
        mask_b  = ~({DW{1'b1}} << exp_b);
        tick_a  = (s_q.div & mask_a) == mask_a;
        tick_b  = (s_q.div & mask_b) == mask_b;
        tick_sa = tick_a && (s_q.sa >= scale_a);
        tick_sb = tick_b && (s_q.sb >= scale_b);
        s_d     = s_q;
        s_d.div = s_q.div + DW'(1);
        if (tick_a) s_d.sa = tick_sa ? '0 : s_q.sa + SW'(1);
        if (tick_b) s_d.sb = tick_sb ? '0 : s_q.sb + SW'(1);
        tick_o = {tick_sb, tick_sa, tick_b, tick_a};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // A divided rate never ticks on two consecutive clocks
    p_a_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_a && exp_a != '0 |=> !tick_a || exp_a != $past(exp_a));
    p_b_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_b && exp_b != '0 |=> !tick_b || exp_b != $past(exp_b));

endmodule

// File: rtl/pwm_mc_core.sv
module pwm_mc_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic         center,
    input  logic [W-1:0] per_in,
    input  logic [W-1:0] duty_in,
    output logic         active_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         up;
        logic [W-1:0] per;
        logic [W-1:0] duty;
    } core_t;

    core_t s_q, s_d;
    logic  wrap;

    always_comb begin
        s_d  = s_q;
        wrap = 1'b0;
        if (!en) begin
            s_d.cnt  = '0;
            s_d.up   = 1'b1;
            s_d.per  = per_in;
            s_d.duty = duty_in;
        end else if (tick) begin
            if (!center || s_q.up) begin
                if (s_q.per == '0 || s_q.cnt == s_q.per - W'(1)) begin
                    if (center) begin
                        s_d.up = 1'b0;
                    end else begin
                        s_d.cnt = '0;
                        wrap    = 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + W'(1);
                end
            end else begin
                if (s_q.cnt == '0) begin
                    s_d.up = 1'b1;
                    wrap   = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - W'(1);
                end
            end
            if (wrap) begin
                s_d.per  = per_in;
                s_d.duty = duty_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.up <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign active_o = en && (s_q.cnt < s_q.duty);

    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en && s_q.per != '0 |-> s_q.cnt < s_q.per);
    p_buffer_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en && !tick |=> $stable(s_q.per) && $stable(s_q.duty));
    p_disabled_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> s_q.per == $past(per_in) && s_q.duty == $past(duty_in));
    p_full_duty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en && s_q.per != '0 && s_q.duty >= s_q.per |-> active_o);

endmodule

// File: rtl/pwm_mc_pair.sv
module pwm_mc_pair #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    tick,
    input  logic [1:0]    en,
    input  logic [1:0]    pol,
    input  logic [1:0]    center,
    input  logic [3:0]    src,
    input  logic [CW-1:0] per_lo,
    input  logic [CW-1:0] per_hi,
    input  logic [CW-1:0] duty_lo,
    input  logic [CW-1:0] duty_hi,
    input  logic          join_i,
    output logic [1:0]    pin_o
);
    localparam int WW = 2 * CW;

    logic act_lo, act_hi, act_w, act_1;
    logic tick_lo, tick_hi;

    assign tick_lo = tick[src[1:0]];
    assign tick_hi = tick[src[3:2]];

    pwm_mc_core #(.W(CW)) u_lo (
        .clk(clk), .rst_n(rst_n), .en(en[0] && !join_i), .tick(tick_lo),
        .center(center[0]), .per_in(per_lo), .duty_in(duty_lo), .active_o(act_lo)
    );

    pwm_mc_core #(.W(CW)) u_hi (
        .clk(clk), .rst_n(rst_n), .en(en[1] && !join_i), .tick(tick_hi),
        .center(center[1]), .per_in(per_hi), .duty_in(duty_hi), .active_o(act_hi)
    );

    pwm_mc_core #(.W(WW)) u_wide (
        .clk(clk), .rst_n(rst_n), .en(en[1] && join_i), .tick(tick_hi),
        .center(center[1]), .per_in({per_hi, per_lo}), .duty_in({duty_hi, duty_lo}),
        .active_o(act_w)
    );

    always_comb begin
        act_1    = join_i ? act_w : act_hi;
        pin_o[1] = pol[1] ? act_1 : !act_1;
        pin_o[0] = join_i ? 1'b0 : (pol[0] ? act_lo : !act_lo);
    end

    p_split_wide_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !join_i |-> !act_w);
    p_joined_narrow_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        join_i |-> !act_lo && !act_hi);

endmodule

// File: rtl/pwm_mc.sv
module pwm_mc #(
    parameter int NCH = 8,
    parameter int CW  = 8,
    parameter int AW  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          sd_i,
    output logic [NCH-1:0] pwm_o
);
    import pwm_mc_pkg::*;

    localparam int NPAIR = NCH / 2;
    localparam int EW    = 3;

    typedef struct packed {
        logic [NCH-1:0]          en;
        logic [NCH-1:0]          pol;
        logic [NCH-1:0]          center;
        logic [2*NCH-1:0]        src;
        logic [NPAIR-1:0]        join_b;
        logic [EW-1:0]           exp_a;
        logic [EW-1:0]           exp_b;
        logic [7:0]              scale_a;
        logic [7:0]              scale_b;
        logic [NCH-1:0][CW-1:0]  per;
        logic [NCH-1:0][CW-1:0]  duty;
    } regs_t;

    regs_t r_q, r_d;
    logic [3:0]     ticks;
    logic [NCH-1:0] pin_w;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr[4]) begin
                if (wr_addr[3]) r_d.duty[wr_addr[2:0]] = wr_data;
                else            r_d.per[wr_addr[2:0]]  = wr_data;
            end else begin
                case (wr_addr[3:0])
                    ADDR_ENABLE: r_d.en      = wr_data;
                    ADDR_POL:    r_d.pol     = wr_data;
                    ADDR_CENTER: r_d.center  = wr_data;
                    ADDR_SRC_LO: r_d.src[7:0]  = wr_data;
                    ADDR_SRC_HI: r_d.src[15:8] = wr_data;
                    ADDR_JOIN:   r_d.join_b  = wr_data[NPAIR-1:0];
                    ADDR_EXP: begin
                        r_d.exp_a = wr_data[2:0];
                        r_d.exp_b = wr_data[6:4];
                    end
                    ADDR_SCL_A:  r_d.scale_a = wr_data;
                    ADDR_SCL_B:  r_d.scale_b = wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.pol <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    pwm_mc_prescale #(.DW(8), .EW(EW), .SW(8)) u_pre (
        .clk(clk), .rst_n(rst_n), .exp_a(r_q.exp_a), .exp_b(r_q.exp_b),
        .scale_a(r_q.scale_a), .scale_b(r_q.scale_b), .tick_o(ticks)
    );

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        pwm_mc_pair #(.CW(CW)) u_pair (
            .clk(clk), .rst_n(rst_n), .tick(ticks),
            .en(r_q.en[2*k +: 2]), .pol(r_q.pol[2*k +: 2]),
            .center(r_q.center[2*k +: 2]), .src(r_q.src[4*k +: 4]),
            .per_lo(r_q.per[2*k]), .per_hi(r_q.per[2*k+1]),
            .duty_lo(r_q.duty[2*k]), .duty_hi(r_q.duty[2*k+1]),
            .join_i(r_q.join_b[k]), .pin_o(pin_w[2*k +: 2])
        );
    end

    assign pwm_o = sd_i ? '0 : pin_w;

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        p_disabled_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !sd_i && !r_q.en[n] && !r_q.join_b[n/2] |-> pwm_o[n] == !r_q.pol[n]);
    end

    p_shutdown_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sd_i |-> pwm_o == '0);

endmodule

// File: tb/pwm_mc_test.sv
module pwm_mc_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sd_i = 1'b0;
    logic [7:0] pwm_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_mc uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sd_i(sd_i), .pwm_o(pwm_o)
    );

    typedef struct packed {
        logic [1:0]  src;
        logic        center;
        logic        pol;
        logic [7:0]  per;
        logic [7:0]  duty;
        logic [15:0] exp_hi;
    } vec_t;

    // Ticks: A every clock, B every 4, SA every 2, SB every 4. Window 240 clocks.
    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{2'd0, 1'b0, 1'b1, 8'd10, 8'd3,   16'd72 },  // R2 left
        '{2'd0, 1'b0, 1'b0, 8'd10, 8'd3,   16'd168},  // R5 inverted
        '{2'd0, 1'b1, 1'b1, 8'd10, 8'd3,   16'd72 },  // R3 center
        '{2'd0, 1'b0, 1'b1, 8'd8,  8'd8,   16'd240},  // R4 duty == period
        '{2'd0, 1'b0, 1'b1, 8'd8,  8'd200, 16'd240},  // R4 duty > period
        '{2'd0, 1'b0, 1'b1, 8'd8,  8'd0,   16'd0  },  // R4 duty zero
        '{2'd1, 1'b0, 1'b1, 8'd5,  8'd2,   16'd96 },  // R6 source B
        '{2'd2, 1'b0, 1'b1, 8'd6,  8'd3,   16'd120},  // R6 source SA
        '{2'd3, 1'b1, 1'b1, 8'd3,  8'd1,   16'd80 },  // R6 source SB, center
        '{2'd0, 1'b1, 1'b0, 8'd12, 8'd12,  16'd0  }   // R3 full center, inverted
    };

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_high(input int ch, input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_o[ch]) cnt++;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int hi;
        int lo_hi;
        repeat (3) @(negedge clk);
        // R1: outputs low out of reset
        check("R1 reset outputs", int'(pwm_o), 0);
        rst_n = 1'b1;
        wait_n(2);
        check("R1 outputs after release", int'(pwm_o), 0);

        // R10: prescale and scale registers
        wr(5'd6, 8'h20);   // ea=0, eb=2
        wr(5'd7, 8'd1);    // SA = A/2
        wr(5'd8, 8'd0);    // SB = B

        for (int v = 0; v < NVEC; v++) begin
            wr(5'd0, 8'h00);
            wr(5'd1, {7'h7F, VEC[v].pol});
            wr(5'd2, {7'h00, VEC[v].center});
            wr(5'd3, {6'h00, VEC[v].src});
            wr(5'd16, VEC[v].per);   // R7 written while disabled
            wr(5'd24, VEC[v].duty);
            wr(5'd0, 8'h01);
            wait_n(2);
            count_high(0, 240, hi);
            check($sformatf("R2/R3/R4/R5/R6/R7 vector %0d", v), hi, int'(VEC[v].exp_hi));
        end

        // R7: duty rewrite mid-period waits for period end
        wr(5'd0, 8'h00);
        wr(5'd1, 8'hFF);
        wr(5'd2, 8'h00);
        wr(5'd3, 8'h00);
        wr(5'd16, 8'd100);
        wr(5'd24, 8'd50);
        wr(5'd0, 8'h01);
        wait_n(18);
        wr(5'd24, 8'd0);
        wait_n(4);
        check("R7 old duty holds within period", int'(pwm_o[0]), 1);
        wait_n(80);
        check("R7 new duty after period end", int'(pwm_o[0]), 0);
        wait_n(40);
        check("R7 new duty persists", int'(pwm_o[0]), 0);

        // R8: joined pair 0/1, period 300, duty 100
        wr(5'd0, 8'h00);
        wr(5'd5, 8'h01);
        wr(5'd16, 8'h2C);
        wr(5'd17, 8'h01);
        wr(5'd24, 8'h64);
        wr(5'd25, 8'h00);
        wr(5'd0, 8'h02);
        wait_n(2);
        hi = 0; lo_hi = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (pwm_o[1]) hi++;
            if (pwm_o[0]) lo_hi++;
        end
        check("R8 joined active time", hi, 200);
        check("R8 low pin held low", lo_hi, 0);
        wr(5'd0, 8'h00);
        wr(5'd5, 8'h00);

        // R5/R10: disabled channels rest at inverse polarity
        wr(5'd1, 8'h00);
        wait_n(1);
        check("R5 disabled inactive level", int'(pwm_o), 8'hFF);

        // R9: shutdown forces low, release restores
        sd_i = 1'b1;
        wait_n(1);
        check("R9 shutdown forces low", int'(pwm_o), 0);
        wait_n(5);
        check("R9 shutdown held", int'(pwm_o), 0);
        sd_i = 1'b0;
        wait_n(1);
        check("R9 release restores", int'(pwm_o), 8'hFF);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule